// File: doc/BRIEF.md
# Go-back-N Retransmitting Packet Sender

This block is the transmit half of an end-to-end retransmission scheme at a network interface. A processing element hands it packets, and each packet is given a sequence ID equal to the replay-buffer slot it is written into. The packet then stays in the buffer until the far end confirms it. The receiver cannot put packets back in order. So when a packet is reported bad, or when the oldest unconfirmed packet waits too long, the sender rewinds and sends that packet and every packet after it again.

The receiver's reply arrives as one bundled message per cycle. The message carries an optional cumulative confirmation (the newest sequence ID received intact) and an optional negative report naming a single packet. Every rewind counts as a failed attempt. When the count of failed attempts since the last forward progress reaches a threshold, the block raises a sticky flag that marks the fault as permanent. Software clears the flag with a one-cycle pulse.

Top module: `gbn_arq_tx`

## Requirements
- R1: After reset `out_valid` and `fault_perm` are 0 and `in_ready` is 1.
- R2: Accepted packets are numbered consecutively modulo DEPTH (3-bit IDs for the default depth of 8), starting from 0 after reset. Each is offered on the output in acceptance order, with its ID on `out_seq`.
- R3: At most DEPTH packets are held unconfirmed. While DEPTH are held, `in_ready` is 0 and no further packet is taken.
- R4: A confirmation with `ack_valid`=1 and ID `ack_seq` releases that packet and all older held packets, which re-opens `in_ready`. A confirmation naming an ID that is not currently held has no effect.
- R5: A report with `nack_valid`=1 naming a held packet makes the next offered packet that one, followed by every later held packet in order.
- R6: When `tmo_cycles` is nonzero and the oldest held packet has not been confirmed within about `tmo_cycles` cycles, the sender rewinds to the oldest held packet. The timer restarts when the oldest packet changes and at every rewind. A value of 0 disables the timeout.
- R7: Each rewind, whether reported or timed out, adds one to a failed-attempt count. Any confirmation that releases packets resets that count to 0.
- R8: `fault_perm` rises when the failed-attempt count reaches RETRY_LIMIT (default 3). It stays 1 until `fault_clear` is pulsed.
- R9: When a confirmation and a report arrive in the same cycle, the confirmation is applied first, and the report is then judged against the packets still held.
- R10: A resent packet carries exactly the data first accepted with that ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New packet offered by the processing element |
| in_ready | output | 1 | A buffer slot is free |
| in_data | input | DATA_W | New packet payload |
| out_valid | output | 1 | A packet is being offered to the network |
| out_ready | input | 1 | Network takes the offered packet |
| out_seq | output | SEQ_W | ID of the offered packet |
| out_data | output | DATA_W | Payload of the offered packet |
| ack_valid | input | 1 | Cumulative confirmation present |
| ack_seq | input | SEQ_W | Newest ID received intact |
| nack_valid | input | 1 | Negative report present |
| nack_seq | input | SEQ_W | ID reported bad |
| tmo_cycles | input | TMO_W | Timeout in cycles, 0 disables |
| fault_clear | input | 1 | Clears the permanent-fault flag |
| fault_perm | output | 1 | Sticky permanent-fault flag |

## Verification
The assertions assume that the receiver only names IDs the sender could have issued. Replies naming other IDs are not assumed away: the design filters them, and the properties are guarded by that same filter. The bench keeps the output handshake and the reply channel apart in time. It pauses `out_ready` whenever it sends a confirmation or a report. Because of that, the expected replay order follows directly from the requirement, and the bench does not have to predict any race between a send and a rewind.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
   // reason for a rewind of the send pointer
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_NACK = 2'd1,
      CAUSE_TMO  = 2'd2
   } gbn_cause_e;
endpackage

// File: rtl/gbn_replay_buf.sv
module gbn_replay_buf #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   localparam int SEQ_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [SEQ_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SEQ_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && waddr == SEQ_W'(i)) slot_q[i] <= wdata;
      end
   end

   assign rdata = slot_q[raddr];
endmodule

// File: rtl/gbn_tmo_timer.sv
module gbn_tmo_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   logic [TMO_W-1:0] tmr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                tmr_q <= '0;
      else if (restart || !run)  tmr_q <= '0;
      else if (tmr_q != limit)   tmr_q <= tmr_q + TMO_W'(1);
   end

   assign expire = run && (limit != '0) && (tmr_q == limit);

   // R6
   tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !expire);
endmodule

// File: rtl/gbn_retry_track.sv
module gbn_retry_track #(
   parameter int RETRY_LIMIT = 3,
   localparam int RW = $clog2(RETRY_LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic replay,
   input  logic progress,
   input  logic clear,
   output logic fault
);
   logic [RW-1:0] cnt_q, cnt_base, cnt_nxt;
   logic          flag_q;

   if (RETRY_LIMIT < 1) begin : g_bad_limit
      $error("RETRY_LIMIT must be at least 1");
   end

   always_comb begin
      cnt_base = progress ? '0 : cnt_q;
      cnt_nxt  = (replay && cnt_base != RW'(RETRY_LIMIT)) ? cnt_base + RW'(1) : cnt_base;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         if (replay && cnt_nxt == RW'(RETRY_LIMIT)) flag_q <= 1'b1;
         else if (clear)                            flag_q <= 1'b0;
      end
   end

   assign fault = flag_q;

   // R8
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clear |=> flag_q);
   // R7
   retry_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      progress && !replay |=> cnt_q == '0);
endmodule

// File: rtl/gbn_arq_tx.sv
module gbn_arq_tx
   import gbn_pkg::*;
#(
   parameter int DEPTH       = 8,
   parameter int DATA_W      = 16,
   parameter int TMO_W       = 16,
   parameter int RETRY_LIMIT = 3,
   localparam int SEQ_W = $clog2(DEPTH),
   localparam int CNT_W = SEQ_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [SEQ_W-1:0]  out_seq,
   output logic [DATA_W-1:0] out_data,
   input  logic              ack_valid,
   input  logic [SEQ_W-1:0]  ack_seq,
   input  logic              nack_valid,
   input  logic [SEQ_W-1:0]  nack_seq,
   input  logic [TMO_W-1:0]  tmo_cycles,
   input  logic              fault_clear,
   output logic              fault_perm
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   logic [SEQ_W-1:0] base_q, base_a, ack_rel, nack_rel;
   logic [CNT_W-1:0] cnt_q, off_q, cnt_a, cnt_n, off_f, off_a, off_n, ack_n;
   logic             ack_ok, nack_ok, tmo_hit, in_fire, out_fire, replay;
   gbn_cause_e       cause;

   assign in_ready  = cnt_q < CNT_W'(DEPTH);
   assign in_fire   = in_valid && in_ready;
   assign out_valid = off_q < cnt_q;
   assign out_fire  = out_valid && out_ready;
   assign out_seq   = base_q + off_q[SEQ_W-1:0];

   always_comb begin
      // confirmation first
      ack_rel = ack_seq - base_q;
      ack_ok  = ack_valid && ({1'b0, ack_rel} < cnt_q);
      ack_n   = ack_ok ? {1'b0, ack_rel} + CNT_W'(1) : '0;
      base_a  = base_q + ack_n[SEQ_W-1:0];
      cnt_a   = cnt_q - ack_n;
      off_f   = off_q + CNT_W'(out_fire);
      off_a   = (off_f > ack_n) ? off_f - ack_n : '0;
      // then the report, judged on what is still held
      nack_rel = nack_seq - base_a;
      nack_ok  = nack_valid && ({1'b0, nack_rel} < cnt_a);
      if (nack_ok)                 cause = CAUSE_NACK;
      else if (tmo_hit && !ack_ok) cause = CAUSE_TMO;
      else                         cause = CAUSE_NONE;
      replay = cause != CAUSE_NONE;
      unique case (cause)
         CAUSE_NACK: off_n = {1'b0, nack_rel};
         CAUSE_TMO:  off_n = '0;
         default:    off_n = off_a;
      endcase
      cnt_n = cnt_a + CNT_W'(in_fire);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         off_q  <= '0;
      end else begin
         base_q <= base_a;
         cnt_q  <= cnt_n;
         off_q  <= off_n;
      end
   end

   gbn_replay_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
      .clk   (clk),
      .we    (in_fire),
      .waddr (base_q + cnt_q[SEQ_W-1:0]),
      .wdata (in_data),
      .raddr (out_seq),
      .rdata (out_data)
   );

   gbn_tmo_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cnt_q != '0),
      .restart (ack_ok || replay),
      .limit   (tmo_cycles),
      .expire  (tmo_hit)
   );

   gbn_retry_track #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .replay   (replay),
      .progress (ack_ok),
      .clear    (fault_clear),
      .fault    (fault_perm)
   );

   // R3
   win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH) && off_q <= cnt_q);
   // R4
   ack_slide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ok |=> out_seq - off_q[SEQ_W-1:0] == $past(ack_seq) + SEQ_W'(1));
   // R5
   nack_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nack_ok |=> out_valid && out_seq == $past(nack_seq));
   // R6
   tmo_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_hit && !ack_ok && !nack_ok |=> off_q == '0 && out_valid);
endmodule

// File: tb/sim_gbn_arq_tx.sv
module sim_gbn_arq_tx;
   localparam int DEPTH = 8;
   localparam int DW    = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, out_ready = 1'b0;
   logic ack_valid = 1'b0, nack_valid = 1'b0, fault_clear = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic [2:0] ack_seq = '0, nack_seq = '0;
   logic [15:0] tmo_cycles = '0;
   logic in_ready, out_valid, fault_perm;
   logic [2:0] out_seq;
   logic [DW-1:0] out_data;

   int n_chk = 0, n_fail = 0;
   int unsigned nseq = 0;
   logic [DW-1:0] mdata [DEPTH];
   int unsigned exp_q [$];

   always #2 clk = ~clk;

   gbn_arq_tx u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_seq(out_seq), .out_data(out_data), .ack_valid(ack_valid),
      .ack_seq(ack_seq), .nack_valid(nack_valid), .nack_seq(nack_seq),
      .tmo_cycles(tmo_cycles), .fault_clear(fault_clear), .fault_perm(fault_perm)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every handshake
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R2: actual unexpected seq %0d expected none", out_seq);
         end else begin
            int unsigned s;
            s = exp_q.pop_front();
            check("R2 seq order", 32'(out_seq), 32'(s));
            check("R10 replay data", 32'(out_data), 32'(mdata[s]));
         end
      end
   end

   task automatic push(input logic [DW-1:0] d);
      @(posedge clk); #1;
      mdata[nseq % DEPTH] = d;
      exp_q.push_back(nseq % DEPTH);
      nseq++;
      in_valid = 1'b1; in_data = d;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic reply(input logic av, input int a, input logic nv, input int n);
      @(posedge clk); #1;
      ack_valid = av; ack_seq = 3'(a); nack_valid = nv; nack_seq = 3'(n);
      @(posedge clk); #1;
      ack_valid = 1'b0; nack_valid = 1'b0;
   endtask

   task automatic expect_from(input int first, input int last);
      for (int s = first; ; s = (s + 1) % DEPTH) begin
         exp_q.push_back(s);
         if (s == last) break;
      end
   endtask

   task automatic drain();
      @(posedge clk); #1; out_ready = 1'b1;
      for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
      check("R5 drained", 32'(exp_q.size()), 0);
      @(posedge clk); #1; out_ready = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 out_valid", 32'(out_valid), 0);
      check("R1 in_ready", 32'(in_ready), 1);
      check("R1 fault_perm", 32'(fault_perm), 0);

      // R2 R10: basic numbering, no timeout
      push(16'hA001); push(16'hB002); push(16'hC003);
      drain();
      repeat (40) @(negedge clk);
      check("R6 disabled timeout", 32'(out_valid), 0);

      // R4: release 0,1; stale confirmation; then report on 2
      reply(1, 1, 0, 0);
      reply(1, 1, 0, 0);
      expect_from(2, 2);
      reply(0, 0, 1, 2);
      drain();
      reply(1, 2, 0, 0);

      // R3: fill the window
      @(posedge clk); #1 out_ready = 1'b1;
      for (int i = 0; i < DEPTH; i++) push(16'h1000 + 16'(i));
      drain();
      @(negedge clk);
      check("R3 window full", 32'(in_ready), 0);
      @(posedge clk); #1; in_valid = 1'b1; in_data = 16'hDEAD;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R3 stall", 32'(in_ready), 0);
      end
      @(posedge clk); #1; in_valid = 1'b0;
      @(negedge clk);
      check("R3 no extra packet", 32'(out_valid), 0);
      reply(1, 6, 0, 0);
      @(negedge clk);
      check("R4 window reopens", 32'(in_ready), 1);

      // R9: confirm 0 and report 1 together (held: 7,0,1,2)
      expect_from(1, 2);
      reply(1, 0, 1, 1);
      drain();
      reply(1, 2, 0, 0);

      // R5: go back from the middle
      push(16'h3333); push(16'h4444); push(16'h5555); push(16'h6666);
      drain();
      expect_from(4, 6);
      reply(0, 0, 1, 4);
      drain();
      reply(1, 6, 0, 0);

      // R6: timeout replays from oldest
      tmo_cycles = 16'd10;
      @(posedge clk); #1 out_ready = 1'b1;
      push(16'h7777); push(16'h8888);
      for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
      @(posedge clk); #1 out_ready = 1'b0;
      begin
         int w;
         w = 0;
         while (!out_valid && w < 40) begin @(negedge clk); w++; end
         check("R6 timeout fires", 32'(w >= 2 && w <= 12), 1);
         check("R6 replay oldest", 32'(out_seq), 7);
      end
      expect_from(7, 0);
      drain();
      reply(1, 0, 0, 0);

      // R7 R8: retries escalate to permanent fault
      push(16'h9999);                       // seq 1, not sent
      exp_q.delete();
      repeat (25) @(negedge clk);           // two timeouts
      check("R8 below limit", 32'(fault_perm), 0);
      tmo_cycles = 16'd0;
      reply(0, 0, 1, 1);                    // third attempt
      @(negedge clk);
      check("R8 limit reached", 32'(fault_perm), 1);
      reply(1, 1, 0, 0);
      @(negedge clk);
      check("R8 sticky", 32'(fault_perm), 1);
      @(posedge clk); #1 fault_clear = 1'b1;
      @(posedge clk); #1 fault_clear = 1'b0;
      @(negedge clk);
      check("R8 cleared", 32'(fault_perm), 0);
      push(16'hAAAA); exp_q.delete();       // seq 2
      reply(0, 0, 1, 2); reply(0, 0, 1, 2);
      reply(1, 2, 0, 0);
      push(16'hBBBB); exp_q.delete();       // seq 3
      reply(0, 0, 1, 3); reply(0, 0, 1, 3);
      @(negedge clk);
      check("R7 count reset by progress", 32'(fault_perm), 0);
      reply(1, 3, 0, 0);
      @(negedge clk);
      check("R4 all released", 32'(out_valid), 0);
      check("R2 scoreboard empty", 32'(exp_q.size()), 0);
      finish_run();
   end
endmodule